// File: doc/BRIEF.md
# Round-Robin Multi-Size TLB

This block is a fully associative translation buffer that turns a 32-bit virtual address into a physical address plus a small set of attribute bits. Each slot holds one mapping. A mapping is either a 1 MB section, a 64 KB large page or a 4 KB small page. A lookup is presented for one cycle, and the registered result shows hit or miss, the translated address and the attributes one clock later. The physical address keeps the untranslated low bits for the mapping's size.

When a lookup misses, an external table walker installs the new mapping through the fill port. The slot that receives it is picked by a round-robin pointer. Two flush operations exist: one clears every slot, and one clears the slots whose mapping covers a given virtual page. The second is present only when the instance is built for the data stream. A build for the instruction stream accepts the flush-all request only. Separate instances serve the two streams, and permission checks are left to the consumer of the attribute bits.

Top module: `rr_tlb`

## Requirements
- R1: When `lk_valid` is high in cycle N, `rsp_valid` is high in cycle N+1. When `lk_valid` is low, `rsp_valid` is low one cycle later. After reset `rsp_valid` and `rsp_hit` are low.
- R2: Size code 2 is a section. It matches when VA[31:20] equals tag[19:8], and the result is {base[19:8], VA[19:0]}.
- R3: Size code 1 is a large page. It matches when VA[31:16] equals tag[19:4], and the result is {base[19:4], VA[15:0]}.
- R4: Size code 0 is a small page. It matches when VA[31:12] equals the full 20-bit tag, and the result is {base, VA[11:0]}.
- R5: A slot filled with size code 3 never produces a hit.
- R6: On a hit, `rsp_attr` is the stored attribute of the hitting slot. On a miss, `rsp_hit`, `rsp_pa` and `rsp_attr` are all zero.
- R7: A fill writes the slot that the victim pointer names. The pointer is 0 after reset and advances by one per accepted fill, wrapping from ENTRIES-1 to 0. Flushes do not move it, so the 33rd fill overwrites the first slot.
- R8: `flush_all` invalidates every slot in both variants.
- R9: In the data variant (IS_DATA=1), `flush_one` invalidates every valid slot whose mapping covers `flush_vpn` (VA[31:12]). Other slots keep their contents.
- R10: In the instruction variant (IS_DATA=0), `flush_one` has no effect, and a fill in the same cycle proceeds.
- R11: Same-cycle priority is `flush_all` over `flush_one` over fill. A request that loses is dropped without moving the pointer.
- R12: A lookup sees the contents as they were before any fill or flush issued in the same cycle.
- R13: When several slots cover the lookup address, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| fill_valid | input | 1 | Install a mapping in the victim slot |
| fill_vpn | input | 20 | Virtual page, VA[31:12], of the new mapping |
| fill_base | input | 20 | Physical base, PA[31:12], of the new mapping |
| fill_size | input | 2 | 0 small, 1 large, 2 section, 3 never matches |
| fill_attr | input | ATTR_W | Attribute bits carried with the mapping |
| flush_all | input | 1 | Invalidate all slots |
| flush_one | input | 1 | Invalidate slots covering flush_vpn (data variant only) |
| flush_vpn | input | 20 | VA[31:12] for the single flush |
| rsp_valid | output | 1 | Result valid, one cycle after lk_valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 32 | Translated physical address, zero on miss |
| rsp_attr | output | ATTR_W | Attributes of the hit slot, zero on miss |

## Verification
A corrupted valid bit or tag shows up at the next lookup of that page as a wrong hit or a false miss. A wrongly kept size code shows up as a hit on an address outside the mapping, or as a result whose low bits are spliced at the wrong boundary. A victim pointer that slips or moves on a flush writes a mapping into the wrong slot. That is visible only once the round-robin sequence comes back to that slot, so the bench fills every slot, wraps past the first one and probes both the evicted page and a newly installed page. The reference model is compared with the data and instruction instances on every clock, so a divergence is reported in the cycle after the lookup that exposes it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VPN_W = 20;

  typedef enum logic [1:0] {
    MAP_SMALL   = 2'd0,
    MAP_LARGE   = 2'd1,
    MAP_SECTION = 2'd2,
    MAP_NONE    = 2'd3
  } map_size_e;

  // True when a mapping of the given size and tag covers the page number.
  function automatic logic map_covers(logic [VPN_W-1:0] tag, map_size_e sz,
                                      logic [VPN_W-1:0] vpn);
    case (sz)
      MAP_SMALL:   return tag == vpn;
      MAP_LARGE:   return tag[19:4] == vpn[19:4];
      MAP_SECTION: return tag[19:8] == vpn[19:8];
      default:     return 1'b0;
    endcase
  endfunction

  // Splice the physical base with the untranslated offset for the size.
  function automatic logic [31:0] map_join(logic [VPN_W-1:0] base, map_size_e sz,
                                           logic [31:0] va);
    case (sz)
      MAP_SMALL:   return {base, va[11:0]};
      MAP_LARGE:   return {base[19:4], va[15:0]};
      MAP_SECTION: return {base[19:8], va[19:0]};
      default:     return '0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              kill,
  input  logic [VPN_W-1:0]  wr_tag,
  input  logic [1:0]        wr_size,
  input  logic [VPN_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [VPN_W-1:0]  fl_vpn,
  output logic              lk_hit,
  output logic              fl_hit,
  output logic              valid_o,
  output logic [VPN_W-1:0]  base_o,
  output logic [1:0]        size_o,
  output logic [ATTR_W-1:0] attr_o
);

  logic              valid_q, valid_n;
  logic [VPN_W-1:0]  tag_q, base_q;
  map_size_e         size_q;
  logic [ATTR_W-1:0] attr_q;
  logic              load;

  assign load = wr_en && !kill;

  always_comb begin
    valid_n = valid_q;
    if (kill)       valid_n = 1'b0;
    else if (wr_en) valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q  <= wr_tag;
      size_q <= map_size_e'(wr_size);
      base_q <= wr_base;
      attr_q <= wr_attr;
    end
  end

  assign lk_hit  = valid_q && map_covers(tag_q, size_q, lk_vpn);
  assign fl_hit  = valid_q && map_covers(tag_q, size_q, fl_vpn);
  assign valid_o = valid_q;
  assign base_o  = base_q;
  assign size_o  = size_q;
  assign attr_o  = attr_q;

  p_kill_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid_q);
  p_load_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid_q && tag_q == $past(wr_tag) && base_q == $past(wr_base));

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (adv) ptr_n = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr_o = ptr_q;

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == LAST) |=> ptr_q == '0);
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

endmodule

// File: rtl/tlb_hit_pick.sv
module tlb_hit_pick
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ATTR_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             match_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  base_i,
  input  logic [ENTRIES-1:0][1:0]        size_i,
  input  logic [ENTRIES-1:0][ATTR_W-1:0] attr_i,
  input  logic [31:0]                    va_i,
  output logic                           hit_o,
  output logic [31:0]                    pa_o,
  output logic [ATTR_W-1:0]              attr_o
);

  logic [IDX_W-1:0] sel;

  // Scan downward so the lowest matching slot is the last one recorded.
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) sel = IDX_W'(i);
    end
  end

  assign hit_o  = |match_i;
  assign pa_o   = hit_o ? map_join(base_i[sel], map_size_e'(size_i[sel]), va_i) : '0;
  assign attr_o = hit_o ? attr_i[sel] : '0;

endmodule

// File: rtl/rr_tlb.sv
module rr_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ATTR_W  = 4,
  parameter bit IS_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  input  logic              fill_valid,
  input  logic [19:0]       fill_vpn,
  input  logic [19:0]       fill_base,
  input  logic [1:0]        fill_size,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [19:0]       flush_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic                             one_en, fill_en;
  logic [IDX_W-1:0]                 victim;
  logic [ENTRIES-1:0]               lk_match, fl_match, valid_vec, kill_vec, wr_vec;
  logic [ENTRIES-1:0][VPN_W-1:0]    base_vec;
  logic [ENTRIES-1:0][1:0]          size_vec;
  logic [ENTRIES-1:0][ATTR_W-1:0]   attr_vec;
  logic                             hit_c;
  logic [31:0]                      pa_c;
  logic [ATTR_W-1:0]                attr_c;

  generate
    if (IS_DATA) begin : g_dside
      assign one_en = flush_one && !flush_all;
      p_single_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        one_en |=> (valid_vec & $past(fl_match)) == '0);
    end else begin : g_iside
      assign one_en = 1'b0;
      p_single_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_one && !flush_all && !fill_valid) |=> valid_vec == $past(valid_vec));
    end
  endgenerate

  assign fill_en = fill_valid && !flush_all && !one_en;

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fill_en),
    .ptr_o (victim)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign kill_vec[i] = flush_all || (one_en && fl_match[i]);
    assign wr_vec[i]   = fill_en && (victim == IDX_W'(i));

    tlb_entry #(.ATTR_W(ATTR_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_vec[i]),
      .kill    (kill_vec[i]),
      .wr_tag  (fill_vpn),
      .wr_size (fill_size),
      .wr_base (fill_base),
      .wr_attr (fill_attr),
      .lk_vpn  (lk_va[31:12]),
      .fl_vpn  (flush_vpn),
      .lk_hit  (lk_match[i]),
      .fl_hit  (fl_match[i]),
      .valid_o (valid_vec[i]),
      .base_o  (base_vec[i]),
      .size_o  (size_vec[i]),
      .attr_o  (attr_vec[i])
    );
  end

  tlb_hit_pick #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) u_pick (
    .match_i (lk_match),
    .base_i  (base_vec),
    .size_i  (size_vec),
    .attr_i  (attr_vec),
    .va_i    (lk_va),
    .hit_o   (hit_c),
    .pa_o    (pa_c),
    .attr_o  (attr_c)
  );

  logic              valid_n, hit_n;
  logic [31:0]       pa_n;
  logic [ATTR_W-1:0] attr_n;

  always_comb begin
    valid_n = lk_valid;
    hit_n   = lk_valid && hit_c;
    pa_n    = hit_n ? pa_c : '0;
    attr_n  = hit_n ? attr_c : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= valid_n;
      rsp_hit   <= hit_n;
      rsp_pa    <= pa_n;
      rsp_attr  <= attr_n;
    end
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_pa == '0 && rsp_attr == '0);
  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_vec == '0);
  p_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $onehot0(wr_vec) && wr_vec == '0);

endmodule

// File: tb/rr_tlb_tb.sv
`timescale 1ns/1ps
module rr_tlb_tb;

  localparam int N = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        lk_valid, fill_valid, flush_all, flush_one;
  logic [31:0] lk_va;
  logic [19:0] fill_vpn, fill_base, flush_vpn;
  logic [1:0]  fill_size;
  logic [3:0]  fill_attr;

  logic        d_valid, d_hit, i_valid, i_hit;
  logic [31:0] d_pa, i_pa;
  logic [3:0]  d_attr, i_attr;

  rr_tlb #(.ENTRIES(N), .ATTR_W(4), .IS_DATA(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_base(fill_base),
    .fill_size(fill_size), .fill_attr(fill_attr), .flush_all(flush_all),
    .flush_one(flush_one), .flush_vpn(flush_vpn), .rsp_valid(d_valid),
    .rsp_hit(d_hit), .rsp_pa(d_pa), .rsp_attr(d_attr));

  rr_tlb #(.ENTRIES(N), .ATTR_W(4), .IS_DATA(1'b0)) u_dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_base(fill_base),
    .fill_size(fill_size), .fill_attr(fill_attr), .flush_all(flush_all),
    .flush_one(flush_one), .flush_vpn(flush_vpn), .rsp_valid(i_valid),
    .rsp_hit(i_hit), .rsp_pa(i_pa), .rsp_attr(i_attr));

  // Reference model: index 0 is the data variant, index 1 the instruction variant.
  bit          mv   [2][N];
  logic [19:0] mtag [2][N];
  logic [1:0]  msz  [2][N];
  logic [19:0] mpa  [2][N];
  logic [3:0]  mat  [2][N];
  int          mptr [2];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic bit covers(int k, int e, logic [19:0] vpn);
    if (!mv[k][e]) return 0;
    case (msz[k][e])
      2'd0:    return vpn == mtag[k][e];
      2'd1:    return vpn[19:4] == mtag[k][e][19:4];
      2'd2:    return vpn[19:8] == mtag[k][e][19:8];
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] expect_pa(int k, int e, logic [31:0] va);
    case (msz[k][e])
      2'd0:    return {mpa[k][e], va[11:0]};
      2'd1:    return {mpa[k][e][19:4], va[15:0]};
      default: return {mpa[k][e][19:8], va[19:0]};
    endcase
  endfunction

  task automatic idle();
    lk_valid = 0; lk_va = '0; fill_valid = 0; fill_vpn = '0; fill_base = '0;
    fill_size = '0; fill_attr = '0; flush_all = 0; flush_one = 0; flush_vpn = '0;
  endtask

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Applies the inputs already driven for one clock and compares both instances.
  task automatic cycle(string req);
    bit          ev;
    bit          eh [2];
    logic [31:0] ep [2];
    logic [3:0]  ea [2];
    ev = lk_valid;
    for (int k = 0; k < 2; k++) begin
      eh[k] = 0; ep[k] = '0; ea[k] = '0;
      if (lk_valid) begin
        for (int e = N - 1; e >= 0; e--) begin
          if (covers(k, e, lk_va[31:12])) begin
            eh[k] = 1; ep[k] = expect_pa(k, e, lk_va); ea[k] = mat[k][e];
          end
        end
      end
    end
    for (int k = 0; k < 2; k++) begin
      if (flush_all) begin
        for (int e = 0; e < N; e++) mv[k][e] = 0;
      end else if (flush_one && k == 0) begin
        for (int e = 0; e < N; e++) if (covers(k, e, flush_vpn)) mv[k][e] = 0;
      end else if (fill_valid) begin
        mv[k][mptr[k]]   = 1;
        mtag[k][mptr[k]] = fill_vpn;
        msz[k][mptr[k]]  = fill_size;
        mpa[k][mptr[k]]  = fill_base;
        mat[k][mptr[k]]  = fill_attr;
        mptr[k]          = (mptr[k] + 1) % N;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cmp(req, "data valid", 32'(d_valid), 32'(ev));
    cmp(req, "data hit",   32'(d_hit),   32'(eh[0]));
    cmp(req, "data pa",    d_pa,         ep[0]);
    cmp(req, "data attr",  32'(d_attr),  32'(ea[0]));
    cmp(req, "inst valid", 32'(i_valid), 32'(ev));
    cmp(req, "inst hit",   32'(i_hit),   32'(eh[1]));
    cmp(req, "inst pa",    i_pa,         ep[1]);
    cmp(req, "inst attr",  32'(i_attr),  32'(ea[1]));
    idle();
  endtask

  task automatic look(string req, logic [31:0] va);
    lk_valid = 1; lk_va = va; cycle(req);
  endtask

  task automatic fill(string req, logic [19:0] vpn, logic [19:0] base,
                      logic [1:0] sz, logic [3:0] at);
    fill_valid = 1; fill_vpn = vpn; fill_base = base; fill_size = sz; fill_attr = at;
    cycle(req);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    for (int k = 0; k < 2; k++) begin
      mptr[k] = 0;
      for (int e = 0; e < N; e++) mv[k][e] = 0;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, idle then a lookup on an empty buffer (R6 miss)
    cycle("R1");
    look("R6", 32'h1234_5678);
    // R2 section, R3 large page, R4 small page
    fill("R7", 20'h12300, 20'hABC00, 2'd2, 4'h5);
    look("R2", 32'h1234_5678);
    look("R2", 32'h1240_0000);
    fill("R7", 20'h45670, 20'h89AB0, 2'd1, 4'h9);
    look("R3", 32'h4567_BEEF);
    look("R3", 32'h4568_0000);
    fill("R7", 20'h00003, 20'h77777, 2'd0, 4'hC);
    look("R4", 32'h0000_3ABC);
    look("R4", 32'h0000_4ABC);
    // R5: size code 3 never matches
    fill("R5", 20'h99999, 20'h11111, 2'd3, 4'h1);
    look("R5", 32'h9999_9000);
    // R13: small page inside the section lands in a higher slot
    fill("R13", 20'h12300, 20'h55555, 2'd0, 4'h3);
    look("R13", 32'h1230_0010);
    // R12: lookup in the same cycle as a fill sees the old contents
    lk_valid = 1; lk_va = 32'h0ABC_D123;
    fill_valid = 1; fill_vpn = 20'h0ABCD; fill_base = 20'h22222; fill_size = 2'd0; fill_attr = 4'h7;
    cycle("R12");
    look("R12", 32'h0ABC_D123);
    // R9 / R10: single flush covering both the section and the small page
    flush_one = 1; flush_vpn = 20'h12300; cycle("R9");
    look("R9", 32'h1230_0010);
    look("R9", 32'h4567_0001);
    look("R10", 32'h1230_0010);
    // R11: flush_one with a fill, then flush_all with a fill
    flush_one = 1; flush_vpn = 20'h45670;
    fill_valid = 1; fill_vpn = 20'h0C0DE; fill_base = 20'h33333; fill_size = 2'd0; fill_attr = 4'h2;
    cycle("R11");
    look("R11", 32'h0C0D_E000);
    look("R10", 32'h4567_0000);
    flush_all = 1; fill_valid = 1; fill_vpn = 20'h0F00D; fill_base = 20'h44444;
    cycle("R11");
    look("R8", 32'h0F00_D000);
    look("R8", 32'h0000_3ABC);
    // R7: fill every slot, then wrap past the first
    for (int j = 0; j < N; j++) fill("R7", 20'h10000 + 20'(j), 20'h60000 + 20'(j), 2'd0, 4'(j));
    for (int j = 0; j < N; j++) look("R7", {20'h10000 + 20'(j), 12'h0F0});
    fill("R7", 20'h20000, 20'h70000, 2'd0, 4'hE);
    look("R7", 32'h1000_00F0);
    look("R7", 32'h1000_10F0);
    look("R7", 32'h2000_0004);
    flush_all = 1; cycle("R8");
    look("R8", 32'h2000_0004);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule